// File: doc/BRIEF.md
# 64-bit Global Timer with Periodic Compare

The block keeps a free-running 64-bit up-counter that software reads and writes through a small 32-bit register bus. The counter advances on an enable pulse from an internal prescaler. The prescaler divides the bus clock by a programmable value plus one, so a value of one gives the usual half-rate peripheral tick.

A 64-bit comparator watches the counter. When the counter reaches or passes the compare value and the comparator is enabled, a sticky event flag is set. Software clears the flag by writing 1 to it. The interrupt output is the flag gated by an interrupt enable, so every event that follows a clear appears as a fresh rising edge.

In periodic mode, each match adds a programmed step to the compare value. This gives a regular tick interrupt without software reloading the comparator. The advance is one step per matching cycle only; recovering missed ticks is left to software.

Software reads the 64-bit values as separate low and high words. The counter is one register, so a carry out of the low word changes the high word in the same cycle. A read sequence of high, low, high therefore detects a carry that happened between the reads.

Top module: `gtimer_top`

## Requirements
- R1: The counter is 64 bits wide and resets to 0. It is read as the low word at address 0 and the high word at address 1. It increases by exactly one on each prescaler tick while the run bit (control bit 0) is 1. It holds its value while the run bit is 0.
- R2: Control bits 15:8 hold a prescale value p. While running, the counter advances once every p+1 clock cycles: p=0 gives every cycle, p=1 every second cycle, p=3 every fourth cycle.
- R3: The control register is at address 2. It stores bit 0 (run), bit 1 (compare enable), bit 2 (interrupt enable), bit 3 (periodic mode) and bits 15:8 (prescale). All other bits read as 0, and the register resets to 0.
- R4: A write to address 0 or 1 loads that counter word only while the run bit is 0. While the timer runs, such a write is ignored.
- R5: While compare enable is 1 and the counter is greater than or equal to the compare value, the event flag is 1 from the next cycle on. The flag is read as bit 0 of address 3. With compare enable at 0, the flag never sets.
- R6: Writing a word with bit 0 set to address 3 clears the event flag, unless a match occurs in the same cycle, in which case the flag stays set. Writing 0 to address 3 has no effect.
- R7: The step register is at address 6 and resets to 0. While periodic mode and a match coincide in a cycle, the compare value grows by exactly one step in that cycle, even when the counter lies several steps ahead.
- R8: The interrupt output is 1 exactly when the event flag and interrupt enable are both 1. After a clear, a later match produces a new rising edge.
- R9: A carry out of the low counter word changes the high word in the same cycle as the low word wraps to 0.
- R10: The compare value is read back as its low word at address 4 and its high word at address 5, and resets to 0. Address 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Word address of the register accessed |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt: event flag gated by interrupt enable |

## Verification
The assertions check the following on every cycle:
- a running counter moves by zero or one, and a stopped counter moves only on a counter-word write;
- every match sets the flag, and every rising flag has a match behind it;
- the interrupt never rises without the flag;
- a periodic match adds exactly the step, and otherwise the compare value holds unless it is written.

The bench's scenarios are needed for the rest:
- the exact tick rate for each prescale value;
- writes to a running counter being ignored;
- the carry into the high word being visible;
- the clear colliding with a still-true match;
- the one-step-per-match catch-up;
- the count of fresh interrupt edges.

// File: rtl/gtimer_pkg.sv
`timescale 1ns/1ps
package gtimer_pkg;
    // word addresses of the register map
    localparam int unsigned REG_CNT_BASE = 0;   // counter words, low first
    localparam int unsigned REG_CTRL     = 2;
    localparam int unsigned REG_STAT     = 3;
    localparam int unsigned REG_CMP_BASE = 4;   // compare words, low first
    localparam int unsigned REG_STEP     = 6;

    // control bit positions
    localparam int unsigned CB_RUN  = 0;
    localparam int unsigned CB_CMP  = 1;
    localparam int unsigned CB_IRQ  = 2;
    localparam int unsigned CB_AUTO = 3;
    localparam int unsigned CB_PSC  = 8;
endpackage

// File: rtl/gtimer_prescale.sv
`timescale 1ns/1ps
module gtimer_prescale #(
    parameter int unsigned PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    typedef struct packed {
        logic [PSC_W-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.pre >= psc);
        if (!run) begin
            st_d.pre = '0;
        end else if (tick) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + PSC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/gtimer_count.sv
`timescale 1ns/1ps
module gtimer_count #(
    parameter int unsigned CNT_W = 64,
    parameter int unsigned BUS_W = 32,
    localparam int unsigned NW   = CNT_W / BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [NW-1:0]    ld,
    input  logic [BUS_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            // one adder over the full width: a carry reaches every word at once
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end else begin
            for (int w = 0; w < NW; w++) begin
                if (ld[w]) st_d.cnt[w*BUS_W +: BUS_W] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/gtimer_cmp.sv
`timescale 1ns/1ps
module gtimer_cmp #(
    parameter int unsigned CNT_W = 64,
    parameter int unsigned BUS_W = 32,
    localparam int unsigned NW   = CNT_W / BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cmp_en,
    input  logic             auto_en,
    input  logic [NW-1:0]    wr_cmp,
    input  logic             wr_step,
    input  logic             clr_req,
    input  logic [BUS_W-1:0] wdata,
    output logic [CNT_W-1:0] cmp_val,
    output logic [BUS_W-1:0] step_val,
    output logic             flag,
    output logic             match
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic [BUS_W-1:0] step;
        logic             flag;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        match = cmp_en && (cnt >= st_q.cmp);
        // periodic re-arm: one step per matching cycle
        if (auto_en && match) begin
            st_d.cmp = st_q.cmp + CNT_W'(st_q.step);
        end
        // a software write to a compare word takes that word over
        for (int w = 0; w < NW; w++) begin
            if (wr_cmp[w]) st_d.cmp[w*BUS_W +: BUS_W] = wdata;
        end
        if (wr_step) st_d.step = wdata;
        // a fresh match wins over a clear in the same cycle
        if (match)        st_d.flag = 1'b1;
        else if (clr_req) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_val  = st_q.cmp;
    assign step_val = st_q.step;
    assign flag     = st_q.flag;
endmodule

// File: rtl/gtimer_top.sv
`timescale 1ns/1ps
module gtimer_top
    import gtimer_pkg::*;
#(
    parameter int unsigned CNT_W  = 64,
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned PSC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int unsigned NW = CNT_W / BUS_W;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic             auto_en;
        logic             irq_en;
        logic             cmp_en;
        logic             run;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic             tick;
    logic [NW-1:0]    ld_cnt;
    logic [NW-1:0]    wr_cmp;
    logic             wr_step;
    logic             clr_req;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] cmp_val;
    logic [BUS_W-1:0] step_val;
    logic             flag;
    logic             match;
    logic             run_en;
    logic             irq_en;
    logic             auto_en;
    logic             cmp_en;

    assign run_en  = ctrl_q.run;
    assign irq_en  = ctrl_q.irq_en;
    assign auto_en = ctrl_q.auto_en;
    assign cmp_en  = ctrl_q.cmp_en;

    // write decode
    always_comb begin
        for (int w = 0; w < NW; w++) begin
            ld_cnt[w] = bus_we && !ctrl_q.run &&
                        (bus_addr == ADDR_W'(REG_CNT_BASE + w));
            wr_cmp[w] = bus_we && (bus_addr == ADDR_W'(REG_CMP_BASE + w));
        end
        wr_step = bus_we && (bus_addr == ADDR_W'(REG_STEP));
        clr_req = bus_we && (bus_addr == ADDR_W'(REG_STAT)) && bus_wdata[0];
    end

    // control register
    always_comb begin
        ctrl_d = ctrl_q;
        if (bus_we && (bus_addr == ADDR_W'(REG_CTRL))) begin
            ctrl_d.run     = bus_wdata[CB_RUN];
            ctrl_d.cmp_en  = bus_wdata[CB_CMP];
            ctrl_d.irq_en  = bus_wdata[CB_IRQ];
            ctrl_d.auto_en = bus_wdata[CB_AUTO];
            ctrl_d.psc     = bus_wdata[CB_PSC +: PSC_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    gtimer_prescale #(.PSC_W(PSC_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ctrl_q.run),
        .psc  (ctrl_q.psc),
        .tick (tick)
    );

    gtimer_count #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .ld   (ld_cnt),
        .wdata(bus_wdata),
        .cnt  (cnt_val)
    );

    gtimer_cmp #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt_val),
        .cmp_en  (ctrl_q.cmp_en),
        .auto_en (ctrl_q.auto_en),
        .wr_cmp  (wr_cmp),
        .wr_step (wr_step),
        .clr_req (clr_req),
        .wdata   (bus_wdata),
        .cmp_val (cmp_val),
        .step_val(step_val),
        .flag    (flag),
        .match   (match)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NW; w++) begin
            if (bus_addr == ADDR_W'(REG_CNT_BASE + w)) bus_rdata = cnt_val[w*BUS_W +: BUS_W];
            if (bus_addr == ADDR_W'(REG_CMP_BASE + w)) bus_rdata = cmp_val[w*BUS_W +: BUS_W];
        end
        if (bus_addr == ADDR_W'(REG_CTRL)) begin
            bus_rdata[CB_RUN]          = ctrl_q.run;
            bus_rdata[CB_CMP]          = ctrl_q.cmp_en;
            bus_rdata[CB_IRQ]          = ctrl_q.irq_en;
            bus_rdata[CB_AUTO]         = ctrl_q.auto_en;
            bus_rdata[CB_PSC +: PSC_W] = ctrl_q.psc;
        end
        if (bus_addr == ADDR_W'(REG_STAT)) bus_rdata = BUS_W'(flag);
        if (bus_addr == ADDR_W'(REG_STEP)) bus_rdata = step_val;
    end

    assign irq = flag && ctrl_q.irq_en;
endmodule

// File: rtl/gtimer_chk.sv
`timescale 1ns/1ps
module gtimer_chk
    import gtimer_pkg::*;
#(
    parameter int unsigned CNT_W  = 64,
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              we,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic [BUS_W-1:0]  step,
    input logic              flag,
    input logic              match,
    input logic              run_en,
    input logic              auto_en,
    input logic              irq
);
    logic             cnt_wr;
    logic             cmp_wr;
    logic [CNT_W-1:0] step_x;

    assign cnt_wr = we && ((addr == ADDR_W'(REG_CNT_BASE)) || (addr == ADDR_W'(REG_CNT_BASE + 1)));
    assign cmp_wr = we && ((addr == ADDR_W'(REG_CMP_BASE)) || (addr == ADDR_W'(REG_CMP_BASE + 1)));
    assign step_x = CNT_W'(step);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));  // R1
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !cnt_wr) |=> (cnt == $past(cnt)));  // R4
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag);  // R5
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(match));  // R5
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);  // R8
    AST_AUTO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && match && !cmp_wr) |=> (cmp == $past(cmp) + $past(step_x)));  // R7
    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(auto_en && match) && !cmp_wr) |=> $stable(cmp));  // R7
endmodule

bind gtimer_top gtimer_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (bus_addr),
    .we     (bus_we),
    .cnt    (cnt_val),
    .cmp    (cmp_val),
    .step   (step_val),
    .flag   (flag),
    .match  (match),
    .run_en (run_en),
    .auto_en(auto_en),
    .irq    (irq)
);

// File: tb/gtimer_top_tb.sv
`timescale 1ns/1ps
module gtimer_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    gtimer_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    // behavioural reference model
    longint unsigned m_cnt, m_cmp;
    int unsigned     m_step, m_psc, m_pre;
    bit              m_run, m_cmpe, m_irqe, m_auto, m_flag;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_cmp = 0; m_step = 0; m_psc = 0; m_pre = 0;
            m_run = 0; m_cmpe = 0; m_irqe = 0; m_auto = 0; m_flag = 0;
        end else begin
            bit tk, mt;
            longint unsigned ncmp;
            tk = m_run && (m_pre >= m_psc);
            mt = m_cmpe && (m_cnt >= m_cmp);
            if (!m_run || tk) m_pre = 0; else m_pre = m_pre + 1;
            if (tk) m_cnt = m_cnt + 1;
            else if (!m_run && bus_we && bus_addr == 0) m_cnt = {m_cnt[63:32], bus_wdata};
            else if (!m_run && bus_we && bus_addr == 1) m_cnt = {bus_wdata, m_cnt[31:0]};
            ncmp = (m_auto && mt) ? m_cmp + longint'(m_step) : m_cmp;
            if (bus_we && bus_addr == 4) ncmp = {ncmp[63:32], bus_wdata};
            if (bus_we && bus_addr == 5) ncmp = {bus_wdata, ncmp[31:0]};
            m_cmp = ncmp;
            if (bus_we && bus_addr == 6) m_step = bus_wdata;
            if (mt) m_flag = 1;
            else if (bus_we && bus_addr == 3 && bus_wdata[0]) m_flag = 0;
            if (bus_we && bus_addr == 2) begin
                m_run = bus_wdata[0]; m_cmpe = bus_wdata[1];
                m_irqe = bus_wdata[2]; m_auto = bus_wdata[3];
                m_psc = int'(bus_wdata[15:8]);
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_cnt[31:0];
            3'd1: return m_cnt[63:32];
            3'd2: return {16'h0, m_psc[7:0], 4'h0, m_auto, m_irqe, m_cmpe, m_run};
            3'd3: return {31'h0, m_flag};
            3'd4: return m_cmp[31:0];
            3'd5: return m_cmp[63:32];
            3'd6: return m_step;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0, 3'd1: return "R1";
            3'd2:       return "R3";
            3'd3:       return "R6";
            3'd6:       return "R7";
            default:    return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    int rises = 0;
    logic irq_prev = 1'b0;
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            chk(tag_of(bus_addr), 64'(bus_rdata), 64'(m_read(bus_addr)));
            chk("R8", 64'(irq), 64'(m_flag && m_irqe));
            if (irq && !irq_prev) rises++;
            irq_prev = irq;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_now(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a; bus_we = 1'b0;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_now(a, v);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            chk(i == 2 ? "R3" : (i < 2 ? "R1" : "R10"), 64'(v), 64'h0);
        end
        chk("R8", 64'(irq), 64'h0);

        // R1: count then freeze
        wr(3'd2, 32'h1);
        idle(20);
        wr(3'd2, 32'h0);
        rd(3'd0, a);
        chk("R1", 64'((a >= 18) && (a <= 26)), 64'h1);
        idle(5);
        rd(3'd0, b);
        chk("R1", 64'(b), 64'(a));

        // R4: counter write ignored while running, accepted when stopped
        wr(3'd2, 32'h1);
        wr(3'd0, 32'hABCD_EF00);
        wr(3'd2, 32'h0);
        rd(3'd0, v);
        chk("R4", 64'(v < 32'd1000), 64'h1);
        wr(3'd0, 32'h0000_1234);
        wr(3'd1, 32'h0000_0077);
        rd(3'd0, v); chk("R4", 64'(v), 64'h1234);
        rd(3'd1, v); chk("R4", 64'(v), 64'h77);

        // R2: prescale 3 then 1
        wr(3'd0, 32'h0); wr(3'd1, 32'h0);
        wr(3'd2, 32'h0000_0301);
        idle(8);
        rd(3'd0, a); idle(39); rd(3'd0, b);
        chk("R2", 64'(b - a), 64'd10);
        wr(3'd2, 32'h0000_0101);
        idle(4);
        rd(3'd0, a); idle(39); rd(3'd0, b);
        chk("R2", 64'(b - a), 64'd20);
        wr(3'd2, 32'h0);

        // R9: carry into the high word
        wr(3'd0, 32'hFFFF_FFFD); wr(3'd1, 32'h5);
        wr(3'd2, 32'h1);
        idle(10);
        wr(3'd2, 32'h0);
        rd(3'd1, v); chk("R9", 64'(v), 64'h6);
        rd(3'd0, v); chk("R9", 64'(v < 32'd20), 64'h1);

        // R5 / R6 / R8: single match
        wr(3'd0, 32'h0); wr(3'd1, 32'h0);
        wr(3'd4, 32'd40); wr(3'd5, 32'h0);
        wr(3'd2, 32'h7);
        idle(10);
        rd(3'd3, v); chk("R5", 64'(v), 64'h0);
        chk("R8", 64'(irq), 64'h0);
        idle(60);
        rd(3'd3, v); chk("R5", 64'(v), 64'h1);
        chk("R8", 64'(irq), 64'h1);
        wr(3'd3, 32'h1);                       // match still true: flag stays
        rd(3'd3, v); chk("R6", 64'(v), 64'h1);
        wr(3'd2, 32'h5);                       // compare off, irq on
        wr(3'd3, 32'h0);
        rd(3'd3, v); chk("R6", 64'(v), 64'h1);
        wr(3'd3, 32'h1);
        rd(3'd3, v); chk("R6", 64'(v), 64'h0);
        chk("R8", 64'(irq), 64'h0);
        idle(5);
        rd(3'd3, v); chk("R5", 64'(v), 64'h0);

        // R7 / R8: periodic ticks
        wr(3'd2, 32'h0);
        wr(3'd0, 32'h0); wr(3'd1, 32'h0);
        wr(3'd4, 32'd30); wr(3'd5, 32'h0);
        wr(3'd6, 32'd25);
        rises = 0;
        wr(3'd2, 32'hF);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (irq) wr(3'd3, 32'h1);
        end
        wr(3'd2, 32'h0);
        chk("R8", 64'(rises >= 6), 64'h1);
        rd(3'd4, a); rd(3'd0, b);
        chk("R7", 64'((a - 32'd30) % 32'd25), 64'h0);
        chk("R7", 64'((a > b) && (a - b <= 32'd25)), 64'h1);

        // R7: one step per matching cycle when far behind
        wr(3'd0, 32'd100); wr(3'd1, 32'h0);
        wr(3'd4, 32'd10); wr(3'd5, 32'h0);
        wr(3'd6, 32'd20);
        wr(3'd3, 32'h1);
        wr(3'd2, 32'hA);
        rd_now(3'd4, v); chk("R7", 64'(v), 64'd10);
        rd(3'd4, v);     chk("R7", 64'(v), 64'd30);
        rd(3'd4, v);     chk("R7", 64'(v), 64'd50);
        idle(10);
        rd(3'd4, v);     chk("R7", 64'(v), 64'd110);
        rd(3'd5, v);     chk("R10", 64'(v), 64'h0);
        rd(3'd3, v);     chk("R5", 64'(v), 64'h1);

        // R10 / R3: unmapped address, unused control bits
        rd(3'd7, v); chk("R10", 64'(v), 64'h0);
        wr(3'd2, 32'hFFFF_FFF0);
        rd(3'd2, v); chk("R3", 64'(v), 64'h0000_FF00);

        idle(2);
        finish_run();
    end
endmodule